// File: doc/BRIEF.md
# Auto-Incrementing Identification Byte Reader

This block answers reads on a host register bus with a fixed stream of identification bytes. An 8-bit pointer selects an entry in a 256-entry table. Reading either of two adjacent data offsets returns the entry under the pointer and moves the pointer forward. The host can therefore walk through the whole table by reading the same address again and again. A read of a third offset moves the pointer back to zero, and so does a system reset.

A 16-bit access to a data offset returns two consecutive entries, the lower-indexed one in the low byte, and moves the pointer on by two. 8-bit and 16-bit accesses can be mixed freely, because both step through the same table.

The table holds the following:

- a device code and a vendor code, each stored low byte first;
- a two-byte logic revision, least significant digit first, set by a parameter;
- four reserved zero bytes;
- a six-character ASCII board name, set by a parameter, followed by two zero bytes;
- 0xFF in every remaining entry.

Read data is registered and appears one cycle after the read strobe.

Top module: `brd_ident_rd`

## Requirements
- R1: After a synchronous reset the pointer is 0, `rd_valid` is 0 and `rd_data` is 0x0000.
- R2: An 8-bit read (`bus_wide`=0) of offset 0x400 or 0x401 returns the entry at the pointer in `rd_data[7:0]`, with `rd_data[15:8]`=0x00, and advances the pointer by one.
- R3: A read of offset 0x402 sets the pointer to 0 and returns 0x0000, whatever the value of `bus_wide`.
- R4: A 16-bit read (`bus_wide`=1) of a data offset returns the entry at pointer p in `rd_data[7:0]` and the entry at p+1 in `rd_data[15:8]`, and advances the pointer by two.
- R5: Entries 0..3 are 0x54, 0x68, 0x35 and 0x14, so 16-bit reads from entry 0 give 0x6854 and then 0x1435.
- R6: Entry 4 holds the low byte of parameter `REV` and entry 5 its high byte. Entries 6..9 are 0x00.
- R7: Entries 10..15 hold the six ASCII characters of parameter `NAME`, first character first. Entries 16 and 17 are 0x00, and entries 18..255 are 0xFF.
- R8: The pointer wraps modulo 256. A 16-bit read at pointer 255 returns {entry 0, entry 255} and leaves the pointer at 1.
- R9: A cycle with `bus_wr`=1, or a read of any offset other than 0x400..0x402, changes neither the pointer nor the data, and raises no `rd_valid`.
- R10: `rd_valid` is high for exactly the one cycle after each accepted read, and `rd_data` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe; writes are ignored |
| bus_wide | input | 1 | 1 selects a 16-bit access |
| bus_addr | input | ADDR_W | Register offset |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid |

## Verification
Every result is due in the cycle after the strobe edge: the data, `rd_valid` and the pointer move all take effect at that edge. The bench raises a strobe on a falling edge, removes it on the next falling edge, and samples `rd_data` and `rd_valid` at that moment, half a period after the capturing edge. The pointer is not a port, so its motion is checked through the byte returned by the following read. Ignored cycles are also checked for a low `rd_valid` in the cycle that follows them.

// File: rtl/ident_pkg.sv
package ident_pkg;
  localparam int unsigned OFS_W = 11;
  localparam logic [OFS_W-1:0] OFS_DATA_LO = 11'h400;
  localparam logic [OFS_W-1:0] OFS_DATA_HI = 11'h401;
  localparam logic [OFS_W-1:0] OFS_REWIND  = 11'h402;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_BYTE   = 2'd1,
    ACC_WORD   = 2'd2,
    ACC_REWIND = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/ident_decode.sv
module ident_decode
  import ident_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_kind_e         kind
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFS_DATA_LO);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFS_DATA_HI);
  localparam logic [ADDR_W-1:0] A_RW = ADDR_W'(OFS_REWIND);

  logic rd_ok;
  logic is_data;

  // A cycle that carries a write strobe is ignored, even if it also reads.
  assign rd_ok   = bus_rd && !bus_wr;
  assign is_data = (bus_addr == A_LO) || (bus_addr == A_HI);

  always_comb begin
    kind = ACC_NONE;
    if (rd_ok) begin
      if (is_data) kind = bus_wide ? ACC_WORD : ACC_BYTE;
      else if (bus_addr == A_RW) kind = ACC_REWIND;
    end
  end

  // R9: a write cycle never decodes to an access
  always_comb begin
    a_r9_write_ignored: assert (!(bus_wr && kind != ACC_NONE));
  end
endmodule

// File: rtl/ident_ptr.sv
module ident_ptr
  import ident_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_kind_e        kind,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] STEP1 = PTR_W'(1);
  localparam logic [PTR_W-1:0] STEP2 = PTR_W'(2);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else begin
      unique case (kind)
        ACC_BYTE:   ptr <= ptr + STEP1;
        ACC_WORD:   ptr <= ptr + STEP2;
        ACC_REWIND: ptr <= '0;
        default:    ptr <= ptr;
      endcase
    end
  end

  a_r1_reset_ptr: assert property (@(posedge clk) rst |=> ptr == '0);
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_BYTE |=> ptr == $past(ptr) + STEP1);
  a_r4_step_two: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_WORD |=> ptr == $past(ptr) + STEP2);
  a_r3_rewind: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_REWIND |=> ptr == '0);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_NONE |=> $stable(ptr));
endmodule

// File: rtl/ident_rom.sv
module ident_rom #(
  parameter int unsigned PTR_W = 8,
  parameter logic [15:0] DEV_ID = 16'h6854,
  parameter logic [15:0] VEN_ID = 16'h1435,
  parameter logic [15:0] REV = 16'h0201,
  parameter logic [47:0] NAME = "IDBLK1"
) (
  input  logic             clk,
  input  logic [PTR_W-1:0] ptr,
  output logic [7:0]       lo_q,
  output logic [7:0]       hi_q
);
  localparam int unsigned DEPTH = 1 << PTR_W;
  localparam int unsigned NAME_BASE = 10;
  localparam int unsigned NAME_LEN = 6;
  localparam int unsigned FILL_BASE = 18;

  function automatic logic [7:0] entry_of(input int unsigned idx);
    logic [7:0] v;
    if (idx == 0) v = DEV_ID[7:0];
    else if (idx == 1) v = DEV_ID[15:8];
    else if (idx == 2) v = VEN_ID[7:0];
    else if (idx == 3) v = VEN_ID[15:8];
    else if (idx == 4) v = REV[7:0];
    else if (idx == 5) v = REV[15:8];
    else if (idx < NAME_BASE) v = 8'h00;
    else if (idx < NAME_BASE + NAME_LEN)
      v = NAME[47 - 8*(idx - NAME_BASE) -: 8];
    else if (idx < FILL_BASE) v = 8'h00;
    else v = 8'hFF;
    return v;
  endfunction

  logic [7:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = entry_of(i);
  end

  logic [PTR_W-1:0] ptr_nx;
  assign ptr_nx = ptr + PTR_W'(1);

  always_ff @(posedge clk) begin
    lo_q <= rom[ptr];
    hi_q <= rom[ptr_nx];
  end
endmodule

// File: rtl/brd_ident_rd.sv
module brd_ident_rd
  import ident_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PTR_W = 8,
  parameter logic [15:0] REV = 16'h0201,
  parameter logic [47:0] NAME = "IDBLK1"
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       rd_data,
  output logic              rd_valid
);
  acc_kind_e        kind;
  acc_kind_e        kind_q;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       lo_q;
  logic [7:0]       hi_q;

  ident_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .kind(kind)
  );

  ident_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .kind(kind), .ptr(ptr)
  );

  ident_rom #(.PTR_W(PTR_W), .REV(REV), .NAME(NAME)) u_rom (
    .clk(clk), .ptr(ptr), .lo_q(lo_q), .hi_q(hi_q)
  );

  always_ff @(posedge clk) begin
    if (rst) kind_q <= ACC_NONE;
    else kind_q <= kind;
  end

  always_comb begin
    unique case (kind_q)
      ACC_BYTE: rd_data = {8'h00, lo_q};
      ACC_WORD: rd_data = {hi_q, lo_q};
      default:  rd_data = 16'h0000;
    endcase
  end

  assign rd_valid = (kind_q != ACC_NONE);

  a_r10_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    kind != ACC_NONE |=> rd_valid);
  a_r10_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_NONE |=> !rd_valid);
  a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_BYTE |=> rd_data[15:8] == 8'h00);
  a_r3_rewind_zero: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_REWIND |=> rd_data == 16'h0000);
endmodule

// File: tb/brd_ident_rd_tb.sv
module brd_ident_rd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b0;
  logic [10:0] bus_addr = 11'h000;
  logic [15:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  brd_ident_rd u_dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_addr(bus_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      errors = errors + 1;
      $display("FAIL R10 watchdog expired actual %0d expected <= %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // op: 0 = byte read 0x400, 1 = byte read 0x401, 2 = word read 0x400, 3 = rewind 0x402
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {2'd2, 16'h6854},  // R5 device code
    {2'd2, 16'h1435},  // R5 vendor code
    {2'd0, 16'h0001},  // R6 revision low
    {2'd1, 16'h0002},  // R6 revision high
    {2'd2, 16'h0000},  // R6 reserved 6,7
    {2'd2, 16'h0000},  // R6 reserved 8,9
    {2'd2, 16'h4449},  // R7 name chars 1,2
    {2'd0, 16'h0042},  // R7 name char 3
    {2'd1, 16'h004C},  // R7 name char 4
    {2'd2, 16'h314B},  // R7 name chars 5,6
    {2'd2, 16'h0000},  // R7 trailing zeros
    {2'd0, 16'h00FF},  // R7 filler
    {2'd3, 16'h0000},  // R3 rewind
    {2'd1, 16'h0054},  // R2 read via 0x401
    {2'd2, 16'h3568},  // R4 odd-aligned word
    {2'd3, 16'h0000},  // R3 rewind again
    {2'd0, 16'h0054}   // R2 after rewind
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic wide,
                        input logic [10:0] addr);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_wide = wide; bus_addr = addr;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [15:0] exp, input string tag);
    logic [10:0] a;
    a = (op == 2'd1) ? 11'h401 : (op == 2'd3) ? 11'h402 : 11'h400;
    access(1'b1, 1'b0, op == 2'd2, a);
    check(tag, rd_data, exp);
    check({tag, " valid"}, {15'd0, rd_valid}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 data", rd_data, 16'h0000);
    check("R1 valid", {15'd0, rd_valid}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VEC[i][17:16] == 2'd3) ? "R3" : (VEC[i][17:16] == 2'd2) ? "R4" : "R2";
      do_op(VEC[i][17:16], VEC[i][15:0], tag);
    end
    // pointer now 1

    // R9: a write to a data offset is ignored
    access(1'b0, 1'b1, 1'b0, 11'h400);
    check("R9 write no valid", {15'd0, rd_valid}, 16'h0000);
    // R9: a read strobe together with a write strobe is ignored
    access(1'b1, 1'b1, 1'b0, 11'h402);
    check("R9 rd+wr no valid", {15'd0, rd_valid}, 16'h0000);
    // R9: a read of an unrelated offset is ignored
    access(1'b1, 1'b0, 1'b0, 11'h403);
    check("R9 other addr no valid", {15'd0, rd_valid}, 16'h0000);
    do_op(2'd0, 16'h0068, "R9 ptr unchanged");

    // R3: rewind with bus_wide set still returns 0 and rewinds
    access(1'b1, 1'b0, 1'b1, 11'h402);
    check("R3 wide rewind", rd_data, 16'h0000);
    do_op(2'd2, 16'h6854, "R3 after wide rewind");

    // R8: word read at pointer 255 wraps
    do_op(2'd3, 16'h0000, "R3");
    for (int k = 0; k < 127; k++) access(1'b1, 1'b0, 1'b1, 11'h400);
    do_op(2'd0, 16'h00FF, "R7 entry 254");
    do_op(2'd2, 16'h54FF, "R8 word wrap");
    do_op(2'd0, 16'h0068, "R8 ptr at 1");

    // R8: byte read at pointer 255 wraps to 0
    do_op(2'd3, 16'h0000, "R3");
    for (int k = 0; k < 127; k++) access(1'b1, 1'b0, 1'b1, 11'h400);
    do_op(2'd1, 16'h00FF, "R7 entry 254");
    do_op(2'd0, 16'h00FF, "R8 entry 255");
    do_op(2'd0, 16'h0054, "R8 byte wrap");

    // R10: valid lasts exactly one cycle
    @(negedge clk);
    check("R10 single cycle", {15'd0, rd_valid}, 16'h0000);

    // R1: mid-run reset returns pointer to 0
    do_op(2'd0, 16'h0068, "R2");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 valid after reset", {15'd0, rd_valid}, 16'h0000);
    do_op(2'd2, 16'h6854, "R1 ptr after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule